// File: doc/BRIEF.md
# Write-Through Snooping Cache Controller

This block is the private cache controller of one processor on a shared-bus multiprocessor. It holds a small direct-mapped array of single-word lines, each with a valid bit and a tag. Reads that find their word in the array are answered locally. Reads that miss fetch the word from memory over the shared bus, fill the line and return the word. Every processor write goes out to memory over the bus, and the written word is also placed in the local line, whether or not that line held the address before.

Coherence with the other processors' caches comes from a snoop port. The port reports every bus transfer made by another master. When another master writes an address that this cache holds, the matching line is invalidated, so the next local read fetches the new value from memory. Snooped reads, and snooped writes to addresses not held here, change nothing. The address is split into an index, which is the low log2(LINES) bits, and a tag, which is the remaining upper bits.

The controller is a four-state machine:
- `S_IDLE` accepts a request. A write goes to `S_WTHRU`. A read hit goes to `S_DONE`. A read miss goes to `S_FILL`.
- `S_FILL` holds a bus read until memory answers, then goes to `S_DONE`.
- `S_WTHRU` holds a bus write until memory answers, then goes to `S_DONE`.
- `S_DONE` presents the answer to the processor for one cycle and returns to `S_IDLE`.

Top module: `wt_snoop_cache`

## Requirements
- R1: A read (cpu_we=0) whose address is not held issues exactly one bus read (bus_we=0) to that address. The word returned by memory is given to the processor and stored in the line.
- R2: A read whose address is held returns the stored word with no bus transaction. cpu_ready is high in the cycle after the request is accepted.
- R3: A write (cpu_we=1) to an address not held issues one bus write (bus_we=1) carrying the address and data. It also allocates the line, so a later read of that address hits.
- R4: A write to a held address updates the line and issues one bus write carrying the address and data.
- R5: A snooped write (snp_valid=1, snp_we=1) to an address held in this cache clears that line. The next read of that address misses and returns the memory value.
- R6: A snooped read (snp_we=0) changes nothing. A snooped write whose tag differs from the line at its index also changes nothing. A following read of the held address still hits.
- R7: bus_req stays high until bus_ready is seen, and bus_addr and bus_we stay stable for as long as bus_req is high.
- R8: If a snooped write to a held address arrives in the same cycle that a local read of that address is accepted, the read is treated as a miss and fetches from memory.
- R9: Reset clears all valid bits and holds cpu_ready and bus_req low. Every first read after reset misses.
- R10: cpu_ready is a one-cycle pulse, given once for each accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Processor request, held until cpu_ready |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Processor word address |
| cpu_wdata | input | DATA_W | Processor write data |
| cpu_rdata | output | DATA_W | Read data, valid with cpu_ready |
| cpu_ready | output | 1 | One-cycle completion pulse |
| bus_req | output | 1 | Bus transfer request |
| bus_we | output | 1 | 1 = bus write, 0 = bus read |
| bus_addr | output | ADDR_W | Bus address |
| bus_wdata | output | DATA_W | Bus write data |
| bus_rdata | input | DATA_W | Memory read data, valid with bus_ready |
| bus_ready | input | 1 | Memory completion |
| snp_valid | input | 1 | A transfer by another master is on the bus |
| snp_we | input | 1 | 1 = that transfer is a write |
| snp_addr | input | ADDR_W | Address of that transfer |

## Verification
A read hit raises cpu_ready in the cycle right after the accepting edge. A miss or a write raises it in the cycle after the edge at which bus_ready is sampled. An invalidation takes effect at the edge where the snoop is sampled, so it shows on the next access.

The bench drives inputs and samples outputs only at falling edges. After each request it waits for cpu_ready there. It counts memory responses between the request and the ready pulse to tell a hit from a miss. Read data is compared with the bench's own memory image. Hit or miss is predicted by a bench function that tracks which address each index holds. The same-cycle conflict is produced by raising the snoop and the request on the same falling edge.

// File: rtl/wtc_pkg.sv
package wtc_pkg;
    typedef enum logic [1:0] {
        S_IDLE,
        S_FILL,
        S_WTHRU,
        S_DONE
    } wtc_state_e;
endpackage

// File: rtl/wtc_line_store.sv
module wtc_line_store #(
    parameter int LINES  = 16,
    parameter int IDX_W  = 4,
    parameter int TAG_W  = 6,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  lk_idx,
    output logic              lk_valid,
    output logic [TAG_W-1:0]  lk_tag,
    output logic [DATA_W-1:0] lk_data,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              snp_wr,
    input  logic [IDX_W-1:0]  snp_idx,
    input  logic [TAG_W-1:0]  snp_tag,
    output logic              inv_hit
);
    logic [LINES-1:0]  vld;
    logic [TAG_W-1:0]  tags [LINES];
    logic [DATA_W-1:0] words [LINES];

    assign lk_valid = vld[lk_idx];
    assign lk_tag   = tags[lk_idx];
    assign lk_data  = words[lk_idx];
    assign inv_hit  = snp_wr && vld[snp_idx] && (tags[snp_idx] == snp_tag);

    // invalidation outranks a fill or write of the same line
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld <= '0;
            for (int i = 0; i < LINES; i++) begin
                tags[i]  <= '0;
                words[i] <= '0;
            end
        end else begin
            for (int i = 0; i < LINES; i++) begin
                if (inv_hit && (snp_idx == IDX_W'(i))) begin
                    vld[i] <= 1'b0;
                end else if (wr_en && (wr_idx == IDX_W'(i))) begin
                    vld[i] <= 1'b1;
                end
                if (wr_en && (wr_idx == IDX_W'(i))) begin
                    tags[i]  <= wr_tag;
                    words[i] <= wr_data;
                end
            end
        end
    end

    p_snoop_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
        inv_hit |=> !vld[$past(snp_idx)]);

    p_alloc_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !(inv_hit && snp_idx == wr_idx))
        |=> (vld[$past(wr_idx)] && tags[$past(wr_idx)] == $past(wr_tag)));
endmodule

// File: rtl/wtc_ctrl.sv
module wtc_ctrl
    import wtc_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 32,
    parameter int IDX_W  = 4,
    localparam int TAG_W = ADDR_W - IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              cpu_ready,
    output logic              bus_req,
    output logic              bus_we,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic [DATA_W-1:0] bus_rdata,
    input  logic              bus_ready,
    output logic [IDX_W-1:0]  lk_idx,
    input  logic              lk_valid,
    input  logic [TAG_W-1:0]  lk_tag,
    input  logic [DATA_W-1:0] lk_data,
    input  logic              inv_hit,
    input  logic [IDX_W-1:0]  inv_idx,
    output logic              wr_en,
    output logic [IDX_W-1:0]  wr_idx,
    output logic [TAG_W-1:0]  wr_tag,
    output logic [DATA_W-1:0] wr_data
);
    wtc_state_e st, st_nx;
    logic [ADDR_W-1:0] a_q;
    logic [DATA_W-1:0] d_q;
    logic [DATA_W-1:0] rd_q;
    logic              hit;
    logic              accept;

    assign lk_idx = cpu_addr[IDX_W-1:0];
    assign hit    = lk_valid && (lk_tag == cpu_addr[ADDR_W-1:IDX_W])
                    && !(inv_hit && inv_idx == lk_idx);
    assign accept = (st == S_IDLE) && cpu_req;

    always_comb begin
        st_nx = st;
        unique case (st)
            S_IDLE:  if (cpu_req) st_nx = cpu_we ? S_WTHRU : (hit ? S_DONE : S_FILL);
            S_FILL:  if (bus_ready) st_nx = S_DONE;
            S_WTHRU: if (bus_ready) st_nx = S_DONE;
            S_DONE:  st_nx = S_IDLE;
            default: st_nx = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st <= S_IDLE;
        else        st <= st_nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_q  <= '0;
            d_q  <= '0;
            rd_q <= '0;
        end else begin
            if (accept) begin
                a_q <= cpu_addr;
                d_q <= cpu_wdata;
                if (!cpu_we) rd_q <= lk_data;
            end
            if (st == S_FILL && bus_ready) rd_q <= bus_rdata;
        end
    end

    always_comb begin
        bus_req   = (st == S_FILL) || (st == S_WTHRU);
        bus_we    = (st == S_WTHRU);
        bus_addr  = a_q;
        bus_wdata = d_q;
        cpu_ready = (st == S_DONE);
        cpu_rdata = rd_q;
        wr_en     = bus_req && bus_ready;
        wr_idx    = a_q[IDX_W-1:0];
        wr_tag    = a_q[ADDR_W-1:IDX_W];
        wr_data   = (st == S_FILL) ? bus_rdata : d_q;
    end

    p_bus_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_ready) |=> (bus_req && $stable(bus_addr) && $stable(bus_we)));

    p_ready_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ready |=> !cpu_ready);

    p_hit_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !cpu_we && lk_valid && lk_tag == cpu_addr[ADDR_W-1:IDX_W] && !inv_hit)
        |=> (!bus_req && cpu_ready));

    p_write_thru_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && cpu_we) |=> (bus_req && bus_we && bus_addr == $past(cpu_addr)));

    p_conflict_miss_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !cpu_we && inv_hit && inv_idx == lk_idx) |=> (bus_req && !bus_we));
endmodule

// File: rtl/wt_snoop_cache.sv
module wt_snoop_cache #(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 32,
    parameter int LINES  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              cpu_ready,
    output logic              bus_req,
    output logic              bus_we,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic [DATA_W-1:0] bus_rdata,
    input  logic              bus_ready,
    input  logic              snp_valid,
    input  logic              snp_we,
    input  logic [ADDR_W-1:0] snp_addr
);
    localparam int IDX_W = $clog2(LINES);
    localparam int TAG_W = ADDR_W - IDX_W;

    logic [IDX_W-1:0]  lk_idx;
    logic              lk_valid;
    logic [TAG_W-1:0]  lk_tag;
    logic [DATA_W-1:0] lk_data;
    logic              wr_en;
    logic [IDX_W-1:0]  wr_idx;
    logic [TAG_W-1:0]  wr_tag;
    logic [DATA_W-1:0] wr_data;
    logic              inv_hit;

    wtc_line_store #(
        .LINES(LINES), .IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)
    ) u_store (
        .clk(clk), .rst_n(rst_n),
        .lk_idx(lk_idx), .lk_valid(lk_valid), .lk_tag(lk_tag), .lk_data(lk_data),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_tag(wr_tag), .wr_data(wr_data),
        .snp_wr(snp_valid && snp_we),
        .snp_idx(snp_addr[IDX_W-1:0]),
        .snp_tag(snp_addr[ADDR_W-1:IDX_W]),
        .inv_hit(inv_hit)
    );

    wtc_ctrl #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .cpu_ready(cpu_ready),
        .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ready(bus_ready),
        .lk_idx(lk_idx), .lk_valid(lk_valid), .lk_tag(lk_tag), .lk_data(lk_data),
        .inv_hit(inv_hit), .inv_idx(snp_addr[IDX_W-1:0]),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_tag(wr_tag), .wr_data(wr_data)
    );

    p_reset_quiet_r9: assert property (@(posedge clk)
        !rst_n |=> (!cpu_ready && !bus_req));
endmodule

// File: tb/tb_wt_snoop_cache.sv
module tb_wt_snoop_cache;
    localparam int AW = 10;
    localparam int DW = 32;
    localparam int NL = 16;
    localparam int IW = 4;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic          rst_n = 1'b0;
    logic          cpu_req = 1'b0, cpu_we = 1'b0;
    logic [AW-1:0] cpu_addr = '0;
    logic [DW-1:0] cpu_wdata = '0;
    logic [DW-1:0] cpu_rdata;
    logic          cpu_ready;
    logic          bus_req, bus_we;
    logic [AW-1:0] bus_addr;
    logic [DW-1:0] bus_wdata;
    logic [DW-1:0] bus_rdata = '0;
    logic          bus_ready = 1'b0;
    logic          snp_valid = 1'b0, snp_we = 1'b0;
    logic [AW-1:0] snp_addr = '0;

    wt_snoop_cache #(.ADDR_W(AW), .DATA_W(DW), .LINES(NL)) dut (
        .clk(clk), .rst_n(rst_n),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .cpu_ready(cpu_ready),
        .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ready(bus_ready),
        .snp_valid(snp_valid), .snp_we(snp_we), .snp_addr(snp_addr)
    );

    int n_chk = 0, n_fail = 0;
    int bus_cnt = 0, hold_err = 0, wait_cnt = 0;
    logic          seen_req = 1'b0;
    logic [AW-1:0] prev_addr = '0;
    logic          last_we = 1'b0;
    logic [AW-1:0] last_addr = '0;
    logic [DW-1:0] last_wdata = '0;
    logic [DW-1:0] mem [1<<AW];
    bit            mv [NL];
    logic [AW-IW-1:0] mt [NL];

    // memory responder
    always @(negedge clk) begin
        if (bus_ready) begin
            bus_ready <= 1'b0;
            seen_req = 1'b0;
        end else if (bus_req) begin
            if (seen_req && bus_addr != prev_addr) hold_err++;
            seen_req = 1'b1;
            prev_addr = bus_addr;
            if (wait_cnt == 0) begin
                bus_cnt++;
                last_we = bus_we; last_addr = bus_addr; last_wdata = bus_wdata;
                if (bus_we) mem[bus_addr] = bus_wdata;
                else        bus_rdata <= mem[bus_addr];
                bus_ready <= 1'b1;
                wait_cnt = $urandom_range(2, 0);
            end else begin
                wait_cnt--;
            end
        end
    end

    task automatic check(input bit ok, input string rq, input string what,
                         input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
        end
    endtask

    function automatic bit m_hit(input logic [AW-1:0] a);
        return mv[a[IW-1:0]] && mt[a[IW-1:0]] == a[AW-1:IW];
    endfunction

    function automatic void m_fill(input logic [AW-1:0] a);
        mv[a[IW-1:0]] = 1'b1;
        mt[a[IW-1:0]] = a[AW-1:IW];
    endfunction

    task automatic cpu_op(input logic we, input logic [AW-1:0] a, input logic [DW-1:0] wd,
                          output logic [DW-1:0] rd, output int used);
        int c0;
        int guard;
        @(negedge clk);
        cpu_we = we; cpu_addr = a; cpu_wdata = wd; cpu_req = 1'b1;
        c0 = bus_cnt; guard = 0;
        do begin
            @(negedge clk);
            guard++;
        end while (!cpu_ready && guard < 100);
        rd = cpu_rdata;
        used = bus_cnt - c0;
        cpu_req = 1'b0;
    endtask

    task automatic do_read(input logic [AW-1:0] a, output int used);
        logic [DW-1:0] rd;
        bit eh;
        eh = m_hit(a);
        cpu_op(1'b0, a, '0, rd, used);
        check(rd == mem[a], eh ? "R2" : "R1", "read data", rd, mem[a]);
        check(used == (eh ? 0 : 1), eh ? "R2" : "R1", "bus reads", used, eh ? 0 : 1);
        if (!eh) check(!last_we && last_addr == a, "R7", "bus read addr", {22'd0, last_addr}, {22'd0, a});
        m_fill(a);
    endtask

    task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
        logic [DW-1:0] rd;
        int used;
        bit eh;
        eh = m_hit(a);
        cpu_op(1'b1, a, d, rd, used);
        check(used == 1 && last_we && last_addr == a && last_wdata == d,
              eh ? "R4" : "R3", "bus write", last_wdata, d);
        check(mem[a] == d, eh ? "R4" : "R3", "memory word", mem[a], d);
        m_fill(a);
    endtask

    task automatic snoop(input logic we, input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        if (we) mem[a] = d;
        snp_valid = 1'b1; snp_we = we; snp_addr = a;
        @(negedge clk);
        snp_valid = 1'b0; snp_we = 1'b0;
        if (we && m_hit(a)) mv[a[IW-1:0]] = 1'b0;
    endtask

    function automatic logic [AW-1:0] pick();
        return {AW'($urandom_range(3, 0)) << IW} | AW'($urandom_range(NL - 1, 0));
    endfunction

    initial begin
        #(8 * 150000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        int used;
        logic [DW-1:0] rd;
        logic [AW-1:0] a, b;
        void'($urandom(32'd1234));
        for (int i = 0; i < (1 << AW); i++) mem[i] = 32'hA5000000 ^ (i * 32'h00010101);
        for (int i = 0; i < NL; i++) begin mv[i] = 1'b0; mt[i] = '0; end
        repeat (4) @(negedge clk);
        check(!cpu_ready && !bus_req, "R9", "outputs in reset", {cpu_ready, bus_req}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!cpu_ready && !bus_req, "R9", "outputs after reset", {cpu_ready, bus_req}, 0);

        // R9: every first read after reset misses
        for (int i = 0; i < 4; i++) begin
            do_read(AW'(i * 5), used);
            check(used == 1, "R9", "first read misses", used, 1);
        end

        // R10: one-cycle ready pulse
        do_read(AW'(0), used);
        @(negedge clk);
        check(!cpu_ready, "R10", "ready drops after one cycle", cpu_ready, 0);

        // R3 allocation then hit
        a = 10'h125;
        do_write(a, 32'hDEADBEEF);
        do_read(a, used);
        check(used == 0, "R3", "written word allocated", used, 0);
        do_write(a, 32'h0BADF00D);
        do_read(a, used);
        check(used == 0, "R4", "write hit keeps line", used, 0);

        // R6: snooped read and snooped write of another tag leave the line alone
        snoop(1'b0, a, '0);
        b = 10'h325;
        snoop(1'b1, b, 32'h77777777);
        do_read(a, used);
        check(used == 0, "R6", "line kept after unrelated snoops", used, 0);

        // R5: snooped write to held address invalidates
        snoop(1'b1, a, 32'h12345678);
        do_read(a, used);
        check(used == 1 && mem[a] == 32'h12345678, "R5", "invalidated line refetched", used, 1);

        // R8: snoop and local read of the same held address in one cycle
        do_read(a, used);
        @(negedge clk);
        mem[a] = 32'hCAFE0008;
        cpu_we = 1'b0; cpu_addr = a; cpu_req = 1'b1;
        snp_valid = 1'b1; snp_we = 1'b1; snp_addr = a;
        used = bus_cnt;
        @(negedge clk);
        snp_valid = 1'b0; snp_we = 1'b0;
        for (int g = 0; g < 100 && !cpu_ready; g++) @(negedge clk);
        rd = cpu_rdata;
        used = bus_cnt - used;
        cpu_req = 1'b0;
        check(used == 1, "R8", "conflicting read goes to bus", used, 1);
        check(rd == 32'hCAFE0008, "R8", "conflicting read data", rd, 32'hCAFE0008);
        m_fill(a);

        // constrained random mix
        for (int n = 0; n < 400; n++) begin
            int r;
            r = $urandom_range(9, 0);
            a = pick();
            if (r < 4)      do_read(a, used);
            else if (r < 7) do_write(a, $urandom());
            else if (r < 9) snoop(1'b1, a, $urandom());
            else            snoop(1'b0, a, '0);
        end

        check(hold_err == 0, "R7", "bus address stable while waiting", hold_err, 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule